// File: doc/BRIEF.md
# Frame-Indexed Address Translation Search Unit

This block translates a logical address into a physical address using a table that holds one entry per physical frame, not one per page. Each entry records whether the frame is in use and, if so, which process ID and page number own it. A lookup presents a process ID, a page number and an offset. The unit then walks the table from frame 0 upward, testing one entry per clock. The index of the first entry whose owner matches becomes the upper part of the physical address, and the offset is passed through unchanged below it. If no entry matches, the lookup ends in a miss, which the surrounding system treats as a page fault.

Software fills and clears the table through a write port. Each write names a frame index and gives the owner process ID, the page number and a valid flag. A frame has only one owner, so two logical pages can never share a frame through this table.

A controller with three states runs the search. ST_IDLE accepts a lookup (transition *start*) and moves to ST_SCAN. ST_SCAN stays in place while it advances the index (transition *step*). It leaves for ST_DONE on a match (transition *found*) or after the last entry (transition *exhausted*). ST_DONE presents the result for one cycle and always returns to ST_IDLE (transition *release*). Default sizes are 16 frames, an 8-bit process ID, a 10-bit page number and a 12-bit offset, and all of them are parameters.

Top module: `ipt_search_unit`

## Requirements
- R1: After reset, `lk_ready` is 1, `res_valid` is 0, and every table entry is invalid, so any lookup misses.
- R2: A write with `wr_en`=1 while `lk_ready`=1 stores `wr_pid`, `wr_page` and `wr_valid` into the entry at index `wr_frame`. The write takes effect at that clock edge.
- R3: On a hit, `res_hit`=1 and `res_paddr` equals the matching frame index in bits [FRAME_W+OFF_W-1:OFF_W], concatenated with the request offset in bits [OFF_W-1:0].
- R4: When several valid entries match the same process ID and page, the lowest index is the one reported.
- R5: A request is accepted on a rising edge where `lk_valid`=1 and `lk_ready`=1. For a match at index m, `res_valid` rises m+1 edges after the accepting edge. For a miss, it rises FRAMES edges after the accepting edge.
- R6: An entry matches only if it is valid and both its process ID and its page number equal the request. When no entry matches, the result has `res_hit`=0 and `res_paddr`=0.
- R7: `res_valid` is high for exactly one cycle, and `lk_ready` is 1 in the cycle that follows.
- R8: From the accepting edge until the result cycle has ended, `lk_ready` is 0. A `lk_valid` asserted in that window starts no lookup and produces no result.
- R9: A write presented while `lk_ready`=0 is dropped, and the table keeps its previous contents.
- R10: Writing an entry with `wr_valid`=0 removes its mapping. Later lookups for that owner then resolve to another matching entry or miss.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request |
| lk_pid | input | PID_W | Request process ID |
| lk_page | input | PAGE_W | Request page number |
| lk_off | input | OFF_W | Request offset within the page |
| lk_ready | output | 1 | Unit is idle and accepts a lookup or a write |
| res_valid | output | 1 | Result present for this cycle |
| res_hit | output | 1 | Result is a hit (0 means page fault) |
| res_paddr | output | FRAME_W+OFF_W | Physical address {frame, offset}; zero on a miss |
| wr_en | input | 1 | Table write strobe |
| wr_frame | input | FRAME_W | Frame index to write |
| wr_pid | input | PID_W | Owner process ID to store |
| wr_page | input | PAGE_W | Owner page number to store |
| wr_valid | input | 1 | Valid flag to store |

## Verification
The assertions assume that `wr_frame` is always below FRAMES, and that a request's fields are sampled only at the accepting edge. The stimulus writes only indices 0 to 15, and it drives every input on the falling edge so that nothing changes near a sampling edge. It deliberately raises `lk_valid` and `wr_en` while a search is running, so that the blocking rules are exercised and not merely assumed. Each scenario measures its latency in edges from the acceptance point and checks it against the matching index that it computes from the entries it wrote.

// File: rtl/ipt_pkg.sv
`timescale 1ns/1ps
package ipt_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SCAN = 2'd1,
        ST_DONE = 2'd2
    } scan_state_t;
endpackage

// File: rtl/ipt_frame_table.sv
`timescale 1ns/1ps
module ipt_frame_table #(
    parameter int FRAMES  = 16,
    parameter int PID_W   = 8,
    parameter int PAGE_W  = 10,
    parameter int FRAME_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic               wr_allow,
    input  logic [FRAME_W-1:0] wr_frame,
    input  logic [PID_W-1:0]   wr_pid,
    input  logic [PAGE_W-1:0]  wr_page,
    input  logic               wr_valid,
    input  logic [FRAME_W-1:0] rd_idx,
    output logic               rd_valid,
    output logic [PID_W-1:0]   rd_pid,
    output logic [PAGE_W-1:0]  rd_page
);
    logic [FRAMES-1:0]        valid_v;
    logic [FRAMES*PID_W-1:0]  pid_v;
    logic [FRAMES*PAGE_W-1:0] page_v;

    // One owner record per physical frame
    for (genvar g = 0; g < FRAMES; g++) begin : g_entry
        logic              sel;
        logic              ent_valid;
        logic [PID_W-1:0]  ent_pid;
        logic [PAGE_W-1:0] ent_page;

        assign sel = wr_en && wr_allow && (wr_frame == FRAME_W'(g));

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ent_valid <= 1'b0;
                ent_pid   <= '0;
                ent_page  <= '0;
            end else if (sel) begin
                ent_valid <= wr_valid;
                ent_pid   <= wr_pid;
                ent_page  <= wr_page;
            end
        end

        assign valid_v[g]                    = ent_valid;
        assign pid_v[g*PID_W +: PID_W]       = ent_pid;
        assign page_v[g*PAGE_W +: PAGE_W]    = ent_page;
    end

    // Single read port for the scanning controller
    assign rd_valid = valid_v[rd_idx];
    assign rd_pid   = pid_v[rd_idx*PID_W +: PID_W];
    assign rd_page  = page_v[rd_idx*PAGE_W +: PAGE_W];

    AST_BLOCKED_WRITE_KEEPS_TABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_allow) |=> ($stable(valid_v) && $stable(pid_v) && $stable(page_v))); // R9
endmodule

// File: rtl/ipt_scan_ctrl.sv
`timescale 1ns/1ps
module ipt_scan_ctrl
    import ipt_pkg::*;
#(
    parameter int FRAMES  = 16,
    parameter int PID_W   = 8,
    parameter int PAGE_W  = 10,
    parameter int OFF_W   = 12,
    parameter int FRAME_W = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     lk_valid,
    input  logic [PID_W-1:0]         lk_pid,
    input  logic [PAGE_W-1:0]        lk_page,
    input  logic [OFF_W-1:0]         lk_off,
    output logic                     lk_ready,
    output logic                     res_valid,
    output logic                     res_hit,
    output logic [FRAME_W+OFF_W-1:0] res_paddr,
    output logic [FRAME_W-1:0]       rd_idx,
    input  logic                     rd_valid,
    input  logic [PID_W-1:0]         rd_pid,
    input  logic [PAGE_W-1:0]        rd_page
);
    localparam logic [FRAME_W-1:0] LAST_IDX = FRAME_W'(FRAMES - 1);

    scan_state_t       state_q, state_d;
    logic [FRAME_W-1:0] idx_q;
    logic [FRAME_W-1:0] frame_q;
    logic               hit_q;
    logic [PID_W-1:0]   req_pid;
    logic [PAGE_W-1:0]  req_page;
    logic [OFF_W-1:0]   req_off;
    logic               scan_match;
    logic               at_last;

    assign scan_match = (state_q == ST_SCAN) && rd_valid &&
                        (rd_pid == req_pid) && (rd_page == req_page);
    assign at_last    = (idx_q == LAST_IDX);
    assign rd_idx     = idx_q;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next state: start, step, found, exhausted, release
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (lk_valid) state_d = ST_SCAN;
            ST_SCAN: if (scan_match || at_last) state_d = ST_DONE;
            ST_DONE: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // Request capture and scan index
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q    <= '0;
            frame_q  <= '0;
            hit_q    <= 1'b0;
            req_pid  <= '0;
            req_page <= '0;
            req_off  <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (lk_valid) begin
                        req_pid  <= lk_pid;
                        req_page <= lk_page;
                        req_off  <= lk_off;
                        idx_q    <= '0;
                        hit_q    <= 1'b0;
                    end
                end
                ST_SCAN: begin
                    if (scan_match) begin
                        hit_q   <= 1'b1;
                        frame_q <= idx_q;
                    end else if (!at_last) begin
                        idx_q <= idx_q + 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    // Outputs
    always_comb begin
        lk_ready  = (state_q == ST_IDLE);
        res_valid = (state_q == ST_DONE);
        res_hit   = res_valid && hit_q;
        res_paddr = res_hit ? {frame_q, req_off} : '0;
    end

    AST_ACCEPT_GOES_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && lk_ready) |=> !lk_ready); // R8
    AST_RESULT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> (!res_valid && lk_ready)); // R7
    AST_HIT_FROM_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_hit) |-> $past(scan_match)); // R3
    AST_MISS_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !res_hit) |-> ($past(idx_q) == LAST_IDX)); // R5
    AST_SCAN_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SCAN) |-> (idx_q <= LAST_IDX)); // R6
endmodule

// File: rtl/ipt_search_unit.sv
`timescale 1ns/1ps
module ipt_search_unit #(
    parameter int FRAMES  = 16,
    parameter int PID_W   = 8,
    parameter int PAGE_W  = 10,
    parameter int OFF_W   = 12,
    parameter int FRAME_W = (FRAMES > 1) ? $clog2(FRAMES) : 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     lk_valid,
    input  logic [PID_W-1:0]         lk_pid,
    input  logic [PAGE_W-1:0]        lk_page,
    input  logic [OFF_W-1:0]         lk_off,
    output logic                     lk_ready,
    output logic                     res_valid,
    output logic                     res_hit,
    output logic [FRAME_W+OFF_W-1:0] res_paddr,
    input  logic                     wr_en,
    input  logic [FRAME_W-1:0]       wr_frame,
    input  logic [PID_W-1:0]         wr_pid,
    input  logic [PAGE_W-1:0]        wr_page,
    input  logic                     wr_valid
);
    logic [FRAME_W-1:0] rd_idx;
    logic               rd_valid;
    logic [PID_W-1:0]   rd_pid;
    logic [PAGE_W-1:0]  rd_page;

    ipt_frame_table #(
        .FRAMES(FRAMES), .PID_W(PID_W), .PAGE_W(PAGE_W), .FRAME_W(FRAME_W)
    ) u_table (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_allow (lk_ready),
        .wr_frame (wr_frame),
        .wr_pid   (wr_pid),
        .wr_page  (wr_page),
        .wr_valid (wr_valid),
        .rd_idx   (rd_idx),
        .rd_valid (rd_valid),
        .rd_pid   (rd_pid),
        .rd_page  (rd_page)
    );

    ipt_scan_ctrl #(
        .FRAMES(FRAMES), .PID_W(PID_W), .PAGE_W(PAGE_W), .OFF_W(OFF_W), .FRAME_W(FRAME_W)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .lk_valid  (lk_valid),
        .lk_pid    (lk_pid),
        .lk_page   (lk_page),
        .lk_off    (lk_off),
        .lk_ready  (lk_ready),
        .res_valid (res_valid),
        .res_hit   (res_hit),
        .res_paddr (res_paddr),
        .rd_idx    (rd_idx),
        .rd_valid  (rd_valid),
        .rd_pid    (rd_pid),
        .rd_page   (rd_page)
    );

    AST_WRITE_INDEX_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (int'(wr_frame) < FRAMES)); // R2
endmodule

// File: tb/sim_ipt_search_unit.sv
`timescale 1ns/1ps
module sim_ipt_search_unit;
    localparam int FRAMES = 16;
    localparam int PID_W  = 8;
    localparam int PAGE_W = 10;
    localparam int OFF_W  = 12;
    localparam int FW     = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic lk_valid = 1'b0;
    logic [PID_W-1:0] lk_pid = '0;
    logic [PAGE_W-1:0] lk_page = '0;
    logic [OFF_W-1:0] lk_off = '0;
    logic lk_ready, res_valid, res_hit;
    logic [FW+OFF_W-1:0] res_paddr;
    logic wr_en = 1'b0;
    logic [FW-1:0] wr_frame = '0;
    logic [PID_W-1:0] wr_pid = '0;
    logic [PAGE_W-1:0] wr_page = '0;
    logic wr_valid = 1'b0;

    int checks = 0;
    int fails = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    ipt_search_unit u0 (
        .clk(clk), .rst_n(rst_n),
        .lk_valid(lk_valid), .lk_pid(lk_pid), .lk_page(lk_page), .lk_off(lk_off),
        .lk_ready(lk_ready), .res_valid(res_valid), .res_hit(res_hit), .res_paddr(res_paddr),
        .wr_en(wr_en), .wr_frame(wr_frame), .wr_pid(wr_pid), .wr_page(wr_page), .wr_valid(wr_valid)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic write_entry(input int f, input int pid, input int page, input bit v);
        @(negedge clk);
        wr_en = 1'b1; wr_frame = FW'(f); wr_pid = PID_W'(pid); wr_page = PAGE_W'(page); wr_valid = v;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // Runs one lookup; n = edges from the accepting edge to the result
    task automatic lookup(input int pid, input int page, input int off,
                          output bit hit, output int paddr, output int n);
        @(negedge clk);
        lk_valid = 1'b1; lk_pid = PID_W'(pid); lk_page = PAGE_W'(page); lk_off = OFF_W'(off);
        @(posedge clk);
        @(negedge clk);
        lk_valid = 1'b0;
        chk("R8 busy after accept", 32'(lk_ready), 32'd0);
        n = 0;
        hit = 0; paddr = -1;
        for (int k = 0; k < 64; k++) begin
            @(posedge clk);
            n++;
            @(negedge clk);
            if (res_valid) break;
        end
        if (!res_valid) begin
            chk("R5 result timeout", 32'd0, 32'd1);
        end else begin
            hit = res_hit;
            paddr = int'(res_paddr);
            @(negedge clk);
            chk("R7 single-cycle result", 32'(res_valid), 32'd0);
            chk("R7 ready after result", 32'(lk_ready), 32'd1);
        end
    endtask

    task automatic expect_hit(input string req, input int pid, input int page, input int off, input int frame);
        bit h; int pa; int n;
        lookup(pid, page, off, h, pa, n);
        chk({req, " hit"}, 32'(h), 32'd1);
        chk({req, " paddr"}, 32'(pa), 32'((frame << OFF_W) | off));
        chk("R5 hit latency", 32'(n), 32'(frame + 1));
    endtask

    task automatic expect_miss(input string req, input int pid, input int page, input int off);
        bit h; int pa; int n;
        lookup(pid, page, off, h, pa, n);
        chk({req, " miss"}, 32'(h), 32'd0);
        chk({req, " miss paddr zero"}, 32'(pa), 32'd0);
        chk("R5 miss latency", 32'(n), 32'(FRAMES));
    endtask

    task automatic t_reset;
        chk("R1 ready at reset", 32'(lk_ready), 32'd1);
        chk("R1 no result at reset", 32'(res_valid), 32'd0);
        expect_miss("R1 empty table", 0, 0, 0);
    endtask

    task automatic t_fill_and_hit;
        write_entry(0, 3, 'h010, 1);
        write_entry(5, 7, 'h02A, 1);
        write_entry(15, 7, 'h02B, 1);
        write_entry(9, 9, 'h100, 0);
        expect_hit("R2 R3 frame0", 3, 'h010, 'hABC, 0);
        expect_hit("R2 R3 frame5", 7, 'h02A, 'h123, 5);
        expect_hit("R3 last frame", 7, 'h02B, 'hFFF, 15);
    endtask

    task automatic t_miss_cases;
        expect_miss("R6 pid only", 7, 'h02C, 'h001);
        expect_miss("R6 page only", 8, 'h02A, 'h001);
        expect_miss("R6 invalid entry", 9, 'h100, 'h002);
    endtask

    task automatic t_priority_and_clear;
        write_entry(12, 3, 'h010, 1);
        expect_hit("R4 lowest index", 3, 'h010, 'h055, 0);
        write_entry(0, 3, 'h010, 0);
        expect_hit("R10 cleared falls to next", 3, 'h010, 'h055, 12);
        write_entry(12, 0, 0, 0);
        expect_miss("R10 all cleared", 3, 'h010, 'h055);
    endtask

    task automatic t_busy_blocking;
        int extra;
        bit got;
        @(negedge clk);
        lk_valid = 1'b1; lk_pid = 8'h55; lk_page = 10'h001; lk_off = '0;
        @(posedge clk);
        @(negedge clk);
        // While busy: try a write and a second lookup
        lk_valid = 1'b1; lk_pid = 8'h07; lk_page = 10'h02A;
        wr_en = 1'b1; wr_frame = 4'd2; wr_pid = 8'h55; wr_page = 10'h001; wr_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        lk_valid = 1'b0; wr_en = 1'b0;
        got = 0;
        for (int k = 0; k < 64; k++) begin
            if (res_valid) begin got = 1; break; end
            @(negedge clk);
        end
        chk("R9 result seen", 32'(got), 32'd1);
        chk("R9 busy write not visible to scan", 32'(res_hit), 32'd0);
        extra = 0;
        @(negedge clk);
        for (int k = 0; k < 24; k++) begin
            if (res_valid) extra++;
            @(negedge clk);
        end
        chk("R8 busy lookup ignored", 32'(extra), 32'd0);
        expect_miss("R9 blocked write dropped", 'h55, 1, 0);
    endtask

    initial begin
        #(200000 * 4);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_fill_and_hit();
        t_miss_cases();
        t_priority_and_clear();
        t_busy_blocking();
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule